// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Coded Operation Select

This block is a purely combinational integer arithmetic-logic unit for a 32-bit datapath. It takes two operands and a 4-bit operation code. It returns one result word and a flag that is high when that word is all zeros. It has no clock and holds no state, so its outputs follow the present inputs and nothing else.

Five operations are decoded:
- bitwise AND and bitwise OR;
- two's-complement addition;
- subtraction, which reuses the same adder with the second operand inverted and a carry-in of one;
- a signed less-than compare, which writes its answer into the lowest bit.

The zero flag lets a branch unit test two registers for equality: it subtracts them and looks at the flag. Codes that name no operation return zero.

Top module: `int_alu`

## Requirements
- R1: Operation code 4'b0000 drives the result with the bitwise AND of operand A and operand B.
- R2: Operation code 4'b0001 drives the result with the bitwise OR of operand A and operand B.
- R3: Operation code 4'b0010 drives the result with A + B, truncated to the low 32 bits (wraps modulo 2^32 with no other indication).
- R4: Operation code 4'b0110 drives the result with A + ~B + 1, which equals A - B modulo 2^32.
- R5: Operation code 4'b0111 drives bit 0 of the result with 1 when A is less than B as signed two's-complement numbers, and 0 otherwise. Bits 31 down to 1 are zero. The answer stays correct when A - B overflows.
- R6: The zero output is 1 exactly when all 32 bits of the result are 0, for every operation code.
- R7: Every operation code other than 0000, 0001, 0010, 0110 and 0111 gives a result of 0, and therefore a zero output of 1.
- R8: The outputs depend only on the present inputs. A change on the inputs reaches the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
Addition is tried with small values, with a carry that ripples through every bit and wraps to zero, and with a step across the signed boundary. These patterns show whether a full carry chain exists and whether the top bit is truncated. Subtraction is tried with positive and negative differences, with a borrow out of the most negative value, and with equal operands. These patterns separate a correct inverted-plus-one path from a missing carry-in and exercise the zero flag. The less-than compare is tried with operands of mixed sign and with pairs whose difference overflows, which a compare that only reads the sign of the difference gets wrong. Every unused code is swept, and inputs are changed between clock edges to show that no register sits on the path.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111
    } alu_op_e;

    // The adder runs in inverted-plus-one mode for subtract and for the compare.
    function automatic logic op_needs_sub(input logic [OP_W-1:0] op);
        return (op == OP_SUB) || (op == OP_SLT);
    endfunction

    function automatic logic op_is_known(input logic [OP_W-1:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_ADD) ||
               (op == OP_SUB) || (op == OP_SLT);
    endfunction

    typedef struct packed {
        logic a_msb;
        logic b_msb;
        logic d_msb;
    } sign_bits_t;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] and_out,
    output logic [WIDTH-1:0] or_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign and_out[i] = a_in[i] & b_in[i];
        assign or_out[i]  = a_in[i] | b_in[i];
    end
endmodule

// File: rtl/alu_addsub_unit.sv
module alu_addsub_unit #(
    parameter int unsigned WIDTH      = 32,
    parameter bit          USE_RIPPLE = 1'b0
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             sub_en,
    output logic [WIDTH-1:0] sum_out
);
    logic [WIDTH-1:0] b_eff;

    assign b_eff = sub_en ? ~b_in : b_in;

    if (USE_RIPPLE) begin : g_ripple
        logic [WIDTH-1:0] carry;
        assign carry[0] = sub_en;
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            assign sum_out[i] = a_in[i] ^ b_eff[i] ^ carry[i];
            if (i < WIDTH - 1) begin : g_cout
                assign carry[i+1] = (a_in[i] & b_eff[i]) |
                                    (carry[i] & (a_in[i] ^ b_eff[i]));
            end
        end
    end else begin : g_infer
        assign sum_out = a_in + b_eff + {{(WIDTH-1){1'b0}}, sub_en};
    end

    // R4: subtracting a value from itself must give zero.
    always_comb begin
        if (sub_en && (a_in == b_in)) begin
            a_r4_self_sub_zero: assert (sum_out == '0)
                else $error("a_r4_self_sub_zero: sum %h", sum_out);
        end
    end
endmodule

// File: rtl/alu_slt_unit.sv
module alu_slt_unit
    import int_alu_pkg::*;
(
    input  sign_bits_t signs,
    output logic       less
);
    // If the signs differ, A is less exactly when A is negative.
    // If the signs match, A - B cannot overflow, so its sign bit is the answer.
    always_comb begin
        if (signs.a_msb != signs.b_msb) less = signs.a_msb;
        else                            less = signs.d_msb;
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int unsigned WIDTH      = 32,
    parameter bit          USE_RIPPLE = 1'b0
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [OP_W-1:0]  op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] and_w, or_w, sum_w;
    logic             sub_en, less_w;
    sign_bits_t       signs;

    assign sub_en = op_needs_sub(op_sel);

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a_in(opnd_a), .b_in(opnd_b), .and_out(and_w), .or_out(or_w)
    );

    alu_addsub_unit #(.WIDTH(WIDTH), .USE_RIPPLE(USE_RIPPLE)) u_addsub (
        .a_in(opnd_a), .b_in(opnd_b), .sub_en(sub_en), .sum_out(sum_w)
    );

    assign signs = '{a_msb: opnd_a[MSB], b_msb: opnd_b[MSB], d_msb: sum_w[MSB]};

    alu_slt_unit u_slt (.signs(signs), .less(less_w));

    always_comb begin
        unique case (op_sel)
            OP_AND:  result = and_w;
            OP_OR:   result = or_w;
            OP_ADD,
            OP_SUB:  result = sum_w;
            OP_SLT:  result = {{(WIDTH-1){1'b0}}, less_w};
            default: result = '0;
        endcase
    end

    assign zero = ~|result;

    always_comb begin
        if (op_sel == OP_ADD) begin
            a_r3_add_wraps: assert (result == WIDTH'(opnd_a + opnd_b))
                else $error("a_r3_add_wraps: %h", result);
        end
        if (op_sel == OP_SUB) begin
            a_r4_sub_diff: assert (result == WIDTH'(opnd_a - opnd_b))
                else $error("a_r4_sub_diff: %h", result);
        end
        if (op_sel == OP_SLT) begin
            a_r5_slt_signed: assert (result[0] == ($signed(opnd_a) < $signed(opnd_b)))
                else $error("a_r5_slt_signed: %h", result);
            a_r5_slt_upper: assert (result[MSB:1] == '0)
                else $error("a_r5_slt_upper: %h", result);
        end
        if (op_sel == OP_AND) begin
            a_r1_and_sub: assert ((result & ~opnd_a) == '0)
                else $error("a_r1_and_sub: %h", result);
        end
        if (!op_is_known(op_sel)) begin
            a_r7_unused_zero: assert (result == '0 && zero)
                else $error("a_r7_unused_zero: %h", result);
        end
    end
endmodule

// File: tb/tb_int_alu.sv
module tb_int_alu;
    localparam int NVEC = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] a, b;
    logic [3:0]  op;
    logic [31:0] result;
    logic        zero;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    int_alu dut (.opnd_a(a), .opnd_b(b), .op_sel(op), .result(result), .zero(zero));

    // {op, a, b, expected}
    localparam logic [99:0] VEC [NVEC] = '{
        {4'h0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000},  // R1
        {4'h0, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0000},  // R1 R6
        {4'h1, 32'hF0F0_F0F0, 32'h0F0F_0000, 32'hFFFF_F0F0},  // R2
        {4'h1, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},  // R2 R6
        {4'h2, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},  // R3
        {4'h2, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},  // R3 wrap
        {4'h2, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},  // R3
        {4'h6, 32'h0000_000A, 32'h0000_0003, 32'h0000_0007},  // R4
        {4'h6, 32'h0000_0003, 32'h0000_000A, 32'hFFFF_FFF9},  // R4
        {4'h6, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF},  // R4 wrap
        {4'h6, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000},  // R4 R6
        {4'h7, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},  // R5
        {4'h7, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000},  // R5
        {4'h7, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001},  // R5 overflow
        {4'h7, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000},  // R5 overflow
        {4'h7, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000},  // R5 equal
        {4'h7, 32'h0000_0002, 32'h0000_0009, 32'h0000_0001},  // R5
        {4'h3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000}   // R7
    };

    task automatic check(input string req, input logic [31:0] exp_r);
        checks++;
        if (result !== exp_r) begin
            errors++;
            $display("FAIL %s result: actual %h expected %h (op %b a %h b %h)",
                     req, result, exp_r, op, a, b);
        end
        checks++;
        if (zero !== (exp_r == 32'h0)) begin
            errors++;
            $display("FAIL R6 zero: actual %b expected %b (op %b)",
                     zero, (exp_r == 32'h0), op);
        end
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        a = '0; b = '0; op = 4'h0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // Initial state with all-zero inputs: AND gives 0 and the zero flag is set (R1, R6).
        #1 check("R1", 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {op, a, b} = VEC[i][99:32];
            #1 check((op == 4'h3) ? "R7" : "R3", VEC[i][31:0]);
        end

        // R7: sweep every unused code with operands that are nonzero for every operation.
        for (int c = 0; c < 16; c++) begin
            if (c inside {0, 1, 2, 6, 7}) continue;
            @(negedge clk);
            op = 4'(c); a = 32'h8765_4321; b = 32'h1357_9BDF;
            #1 check("R7", 32'h0);
        end

        // R8: change inputs between clock edges, with no edge in between.
        @(posedge clk);
        #3 op = 4'h2; a = 32'h0000_0010; b = 32'h0000_0020;
        #1 check("R8", 32'h0000_0030);
        #1 op = 4'h6;
        #1 check("R8", 32'hFFFF_FFF0);
        #1 op = 4'h1; b = 32'h0000_0001;
        #1 check("R2", 32'h0000_0011);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule